// File: doc/BRIEF.md
# Segmentable Deflection Torus Switch

This block is one router tile of a unidirectional two-dimensional torus built from bufferless deflection switches. Traffic enters on a West link, a North link and a local client injection port. It leaves on an East link, a South link and a local delivery port. Routing is dimension ordered: a packet travels East until its column matches, then South until its row matches, and is then handed to the local client. A packet that cannot take the output it wants is not held. It leaves on the link that continues its current direction and comes back after a lap of the ring.

Two isolation multiplexers sit in front of the routing logic, one on each link input. Each has a second input that carries traffic turned back from the far end of the sub-ring. A two-bit configuration register decides, for each dimension, whether the switch takes the normal upstream link or the wrap-back path. When a split is set, the upstream link is ignored completely, so a long ring breaks into shorter rings whose traffic cannot leak across the boundary. The split bits are written by the application between phases and are otherwise held.

A packet is a flat vector: the valid flag in the top bit, then the destination column, then the destination row, then the payload in the low bits. An all-zero vector is an empty slot.

Top module: `seg_torus_switch`

## Requirements
- R1: While reset is asserted, `e_out`, `s_out` and `pe_out` are all zero, and both split bits are cleared, so after reset the switch takes `w_in` and `n_in` and ignores both wrap inputs.
- R2: A valid packet on the selected West input whose column differs from the local column appears unchanged on `e_out` on the clock edge after it is presented.
- R3: A West packet whose column matches but whose row differs turns onto `s_out` on the next edge if no North packet needs South in that cycle; otherwise it is deflected onto `e_out`.
- R4: A North packet that is not addressed to this tile always leaves on `s_out` on the next edge and never on `e_out`, whatever its column field holds.
- R5: A packet whose column and row both match the local tile appears on `pe_out` on the next edge; when West and North both carry such a packet, the North one is delivered and the West one is deflected onto `e_out`.
- R6: A client packet whose column differs needs East, otherwise it needs South. `pe_in_rdy` is high only when that output is not used by link traffic in the current cycle, an accepted packet appears on the needed output on the next edge, and link traffic is never displaced by injection.
- R7: With the horizontal split bit set, `w_in` has no effect and `xwrap_in` is routed as the West input; with it clear, `xwrap_in` has no effect.
- R8: With the vertical split bit set, `n_in` has no effect and `ywrap_in` is routed as the North input; with it clear, `ywrap_in` has no effect.
- R9: The split bits load from `cfg_split_x` and `cfg_split_y` only on an edge where `cfg_we` is high and hold their value otherwise.
- R10: In a torus of these tiles with horizontal splits at every second column, every packet injected toward a tile in its own segment is delivered exactly once to that tile, and no packet ever appears on a link belonging to another segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load enable for the split register |
| cfg_split_x | input | 1 | New value of the horizontal split bit |
| cfg_split_y | input | 1 | New value of the vertical split bit |
| w_in | input | PW | Packet from the upstream horizontal neighbour |
| n_in | input | PW | Packet from the upstream vertical neighbour |
| xwrap_in | input | PW | Horizontal traffic turned back from the end of this sub-ring |
| ywrap_in | input | PW | Vertical traffic turned back from the end of this sub-ring |
| pe_in | input | PW | Packet offered by the local client |
| pe_in_rdy | output | 1 | Client packet is accepted in this cycle |
| e_out | output | PW | Packet to the downstream horizontal neighbour |
| s_out | output | PW | Packet to the downstream vertical neighbour |
| pe_out | output | PW | Packet delivered to the local client |

PW is 1 + XW + YW + DW.

## Verification
The hardest condition to reach from the ports is isolation under load: a packet must be shown never to leak into a neighbouring segment, even after repeated deflections around a short ring. The bench builds a four-by-two torus, sets the horizontal split on every even column so that each pair of columns forms its own ring, and has every tile inject packets to every tile of its segment, including itself, at full rate so that South and delivery contention force deflections. A monitor tags each packet with its source segment and inspects every East and South link and every delivery port on each cycle, while single-tile directed tests cover each contention and wrap-select case cycle by cycle.

// File: rtl/seg_torus_switch.sv
module seg_torus_switch #(
  parameter int DW   = 256,
  parameter int XW   = 4,
  parameter int YW   = 4,
  parameter int MY_X = 0,
  parameter int MY_Y = 0,
  localparam int PW  = 1 + XW + YW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_split_x,
  input  logic          cfg_split_y,
  input  logic [PW-1:0] w_in,
  input  logic [PW-1:0] n_in,
  input  logic [PW-1:0] xwrap_in,
  input  logic [PW-1:0] ywrap_in,
  input  logic [PW-1:0] pe_in,
  output logic          pe_in_rdy,
  output logic [PW-1:0] e_out,
  output logic [PW-1:0] s_out,
  output logic [PW-1:0] pe_out
);
  localparam logic [XW-1:0] LX = XW'(MY_X);
  localparam logic [YW-1:0] LY = YW'(MY_Y);
  localparam int XT = PW - 2;
  localparam int YT = PW - 2 - XW;

  logic split_x_q, split_y_q;

  // isolation multiplexers on the link inputs
  wire [PW-1:0] wsel = split_x_q ? xwrap_in : w_in;
  wire [PW-1:0] nsel = split_y_q ? ywrap_in : n_in;

  wire w_v = wsel[PW-1];
  wire n_v = nsel[PW-1];
  wire p_v = pe_in[PW-1];
  wire w_xm = wsel[XT -: XW] == LX;
  wire w_ym = wsel[YT -: YW] == LY;
  wire n_xm = nsel[XT -: XW] == LX;
  wire n_ym = nsel[YT -: YW] == LY;
  wire p_xm = pe_in[XT -: XW] == LX;

  wire n_home = n_v && n_xm && n_ym;
  wire n_to_s = n_v && !n_home;
  wire w_home = w_v && w_xm && w_ym;
  wire w_to_pe = w_home && !n_home;
  wire w_to_s = w_v && w_xm && !w_ym && !n_to_s;
  wire w_to_e = w_v && !w_to_pe && !w_to_s;

  assign pe_in_rdy = p_xm ? !(n_to_s || w_to_s) : !w_to_e;
  wire p_go = p_v && pe_in_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_x_q <= 1'b0;
      split_y_q <= 1'b0;
    end else if (cfg_we) begin
      split_x_q <= cfg_split_x;
      split_y_q <= cfg_split_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_out  <= '0;
      s_out  <= '0;
      pe_out <= '0;
    end else begin
      e_out  <= w_to_e ? wsel : (p_go && !p_xm) ? pe_in : '0;
      s_out  <= n_to_s ? nsel : w_to_s ? wsel : (p_go && p_xm) ? pe_in : '0;
      pe_out <= n_home ? nsel : w_to_pe ? wsel : '0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (e_out == '0 && s_out == '0 && pe_out == '0));

  assert_west_east_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(split_x_q) && $past(w_in[PW-1]) && $past(w_in[XT -: XW]) != LX)
    |-> e_out == $past(w_in));

  assert_north_south_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(split_y_q) && $past(n_in[PW-1]) &&
     !($past(n_in[XT -: XW]) == LX && $past(n_in[YT -: YW]) == LY))
    |-> s_out == $past(n_in));

  assert_north_deliver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(split_y_q) && $past(n_in[PW-1]) &&
     $past(n_in[XT -: XW]) == LX && $past(n_in[YT -: YW]) == LY)
    |-> pe_out == $past(n_in));

  assert_inject_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_in[PW-1] && pe_in_rdy) |=> (e_out == $past(pe_in) || s_out == $past(pe_in)));

  assert_split_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(split_x_q) && $stable(split_y_q)));
endmodule

// File: tb/tb_seg_torus_switch.sv
module tb_seg_torus_switch;
  localparam int DW = 8, XW = 2, YW = 2;
  localparam int PW = 1 + XW + YW + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  function automatic logic [PW-1:0] mk(int x, int y, int d);
    return {1'b1, XW'(x), YW'(y), DW'(d)};
  endfunction

  task automatic chk(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- single tile at column 1, row 2 ----------------
  logic cfg_we = 0, csx = 0, csy = 0;
  logic [PW-1:0] w_in = '0, n_in = '0, xw_in = '0, yw_in = '0, pe_in = '0;
  logic pe_rdy;
  logic [PW-1:0] e_out, s_out, pe_out;

  seg_torus_switch #(.DW(DW), .XW(XW), .YW(YW), .MY_X(1), .MY_Y(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_split_x(csx), .cfg_split_y(csy),
    .w_in(w_in), .n_in(n_in), .xwrap_in(xw_in), .ywrap_in(yw_in), .pe_in(pe_in),
    .pe_in_rdy(pe_rdy), .e_out(e_out), .s_out(s_out), .pe_out(pe_out));

  task automatic drive(logic [PW-1:0] w, logic [PW-1:0] n, logic [PW-1:0] xw,
                       logic [PW-1:0] yw, logic [PW-1:0] p);
    @(negedge clk);
    w_in = w; n_in = n; xw_in = xw; yw_in = yw; pe_in = p;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(logic sx, logic sy);
    @(negedge clk);
    cfg_we = 1; csx = sx; csy = sy;
    @(negedge clk);
    cfg_we = 0; csx = ~sx; csy = ~sy;
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    chk(e_out == '0 && s_out == '0 && pe_out == '0, "R1 outputs in reset", e_out | s_out | pe_out, '0);
    @(negedge clk); rst_n = 1;
    drive(mk(3, 0, 8'h11), '0, mk(0, 0, 8'h22), mk(1, 3, 8'h33), '0); step();
    chk(e_out == mk(3, 0, 8'h11), "R1 split x clear after reset", e_out, mk(3, 0, 8'h11));
    chk(s_out == '0, "R1 split y clear after reset", s_out, '0);
  endtask

  task automatic t_west_east();
    drive(mk(0, 2, 8'h5a), '0, '0, '0, '0); step();
    chk(e_out == mk(0, 2, 8'h5a), "R2 west to east", e_out, mk(0, 2, 8'h5a));
    chk(s_out == '0 && pe_out == '0, "R2 no other output", s_out | pe_out, '0);
  endtask

  task automatic t_west_turn();
    drive(mk(1, 0, 8'h61), '0, '0, '0, '0); step();
    chk(s_out == mk(1, 0, 8'h61), "R3 west turns south", s_out, mk(1, 0, 8'h61));
    drive(mk(1, 0, 8'h62), mk(1, 3, 8'h63), '0, '0, '0); step();
    chk(s_out == mk(1, 3, 8'h63), "R3 north keeps south", s_out, mk(1, 3, 8'h63));
    chk(e_out == mk(1, 0, 8'h62), "R3 west deflected east", e_out, mk(1, 0, 8'h62));
  endtask

  task automatic t_north();
    drive('0, mk(2, 0, 8'h71), '0, '0, '0); step();
    chk(s_out == mk(2, 0, 8'h71), "R4 north stays south", s_out, mk(2, 0, 8'h71));
    chk(e_out == '0, "R4 north never east", e_out, '0);
  endtask

  task automatic t_deliver();
    drive(mk(1, 2, 8'h81), '0, '0, '0, '0); step();
    chk(pe_out == mk(1, 2, 8'h81), "R5 west delivered", pe_out, mk(1, 2, 8'h81));
    drive(mk(1, 2, 8'h82), mk(1, 2, 8'h83), '0, '0, '0); step();
    chk(pe_out == mk(1, 2, 8'h83), "R5 north wins delivery", pe_out, mk(1, 2, 8'h83));
    chk(e_out == mk(1, 2, 8'h82), "R5 west deflected", e_out, mk(1, 2, 8'h82));
  endtask

  task automatic t_inject();
    drive('0, '0, '0, '0, mk(3, 1, 8'h91)); #1;
    chk(pe_rdy == 1'b1, "R6 ready when east free", {12'b0, pe_rdy}, 1);
    step();
    chk(e_out == mk(3, 1, 8'h91), "R6 injected east", e_out, mk(3, 1, 8'h91));
    drive(mk(0, 0, 8'h92), '0, '0, '0, mk(3, 1, 8'h93)); #1;
    chk(pe_rdy == 1'b0, "R6 blocked by west traffic", {12'b0, pe_rdy}, 0);
    step();
    chk(e_out == mk(0, 0, 8'h92), "R6 link traffic kept", e_out, mk(0, 0, 8'h92));
    drive('0, mk(1, 0, 8'h94), '0, '0, mk(1, 0, 8'h95)); #1;
    chk(pe_rdy == 1'b0, "R6 blocked by north traffic", {12'b0, pe_rdy}, 0);
    step();
    chk(s_out == mk(1, 0, 8'h94), "R6 south kept for north", s_out, mk(1, 0, 8'h94));
    drive('0, '0, '0, '0, mk(1, 0, 8'h96)); #1;
    chk(pe_rdy == 1'b1, "R6 ready when south free", {12'b0, pe_rdy}, 1);
    step();
    chk(s_out == mk(1, 0, 8'h96), "R6 injected south", s_out, mk(1, 0, 8'h96));
    drive('0, '0, '0, '0, '0);
  endtask

  task automatic t_split_x();
    write_cfg(1, 0);
    drive(mk(3, 0, 8'ha1), '0, mk(0, 0, 8'ha2), '0, '0); step();
    chk(e_out == mk(0, 0, 8'ha2), "R7 wrap selected", e_out, mk(0, 0, 8'ha2));
    drive(mk(1, 2, 8'ha3), '0, '0, '0, '0); step();
    chk(pe_out == '0 && e_out == '0, "R7 west ignored", pe_out | e_out, '0);
    drive('0, '0, '0, '0, '0); step();
    chk(e_out == '0, "R9 split x held without write", e_out, '0);
    drive(mk(3, 0, 8'ha4), '0, '0, '0, '0); step();
    chk(e_out == '0, "R9 west still ignored", e_out, '0);
    write_cfg(0, 0);
    drive(mk(3, 0, 8'ha5), '0, mk(1, 2, 8'ha6), '0, '0); step();
    chk(e_out == mk(3, 0, 8'ha5) && pe_out == '0, "R7 wrap ignored when clear", e_out, mk(3, 0, 8'ha5));
  endtask

  task automatic t_split_y();
    write_cfg(0, 1);
    drive('0, mk(1, 0, 8'hb1), '0, mk(1, 2, 8'hb2), '0); step();
    chk(pe_out == mk(1, 2, 8'hb2) && s_out == '0, "R8 wrap selected north", pe_out, mk(1, 2, 8'hb2));
    write_cfg(0, 0);
    drive('0, mk(1, 0, 8'hb3), '0, mk(1, 2, 8'hb4), '0); step();
    chk(s_out == mk(1, 0, 8'hb3) && pe_out == '0, "R8 north wrap ignored", s_out, mk(1, 0, 8'hb3));
    drive('0, '0, '0, '0, '0);
  endtask

  // ---------------- 4x2 torus, horizontal splits on even columns ----------------
  logic ring_we = 0;
  logic [PW-1:0] eo [4][2];
  logic [PW-1:0] so [4][2];
  logic [PW-1:0] rpo [4][2];
  logic [PW-1:0] rpi [4][2];
  logic rrdy [4][2];

  for (genvar gi = 0; gi < 4; gi++) begin : g_col
    for (genvar gj = 0; gj < 2; gj++) begin : g_row
      logic [PW-1:0] wrap_x;
      if (gi % 2 == 0) begin : g_start
        assign wrap_x = eo[gi + 1][gj];
      end else begin : g_mid
        assign wrap_x = '0;
      end
      seg_torus_switch #(.DW(DW), .XW(XW), .YW(YW), .MY_X(gi), .MY_Y(gj)) u_tile (
        .clk(clk), .rst_n(rst_n), .cfg_we(ring_we),
        .cfg_split_x(gi % 2 == 0), .cfg_split_y(1'b0),
        .w_in(eo[(gi + 3) % 4][gj]), .n_in(so[gi][(gj + 1) % 2]),
        .xwrap_in(wrap_x), .ywrap_in('0), .pe_in(rpi[gi][gj]),
        .pe_in_rdy(rrdy[gi][gj]), .e_out(eo[gi][gj]), .s_out(so[gi][gj]),
        .pe_out(rpo[gi][gj]));
    end
  end

  int got [4][2];
  int delivered = 0, misroute = 0, leak = 0;
  bit mon_on = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 2; j++) begin
          if (rpo[i][j][PW-1]) begin
            delivered++;
            got[i][j]++;
            if (rpo[i][j][PW-2 -: XW] != XW'(i) || rpo[i][j][PW-2-XW -: YW] != YW'(j) ||
                rpo[i][j][7] != (i / 2 == 1))
              misroute++;
          end
          if (eo[i][j][PW-1] && eo[i][j][7] != (i / 2 == 1)) leak++;
          if (so[i][j][PW-1] && so[i][j][7] != (i / 2 == 1)) leak++;
        end
      end
    end
  end

  task automatic t_ring();
    int sent [4][2];
    int cyc;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 2; j++) begin
        sent[i][j] = 0; got[i][j] = 0; rpi[i][j] = '0;
      end
    @(negedge clk); ring_we = 1;
    @(negedge clk); ring_we = 0; mon_on = 1;
    cyc = 0;
    while (delivered < 64 && cyc < 3000) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 2; j++) begin
          if (sent[i][j] < 8) begin
            int p = sent[i][j];
            int dx = (i & 2) | ((p >> 1) & 1);
            rpi[i][j] = mk(dx, p & 1, ((i * 2 + j) << 5) | p);
          end else rpi[i][j] = '0;
        end
      #3;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 2; j++)
          if (rpi[i][j][PW-1] && rrdy[i][j]) sent[i][j]++;
      @(negedge clk);
      cyc++;
    end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 2; j++) rpi[i][j] = '0;
    repeat (20) @(negedge clk);
    chk(delivered == 64, "R10 all packets delivered", PW'(delivered), PW'(64));
    chk(misroute == 0, "R10 no misdelivery", PW'(misroute), '0);
    chk(leak == 0, "R10 no cross-segment link traffic", PW'(leak), '0);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 2; j++)
        chk(got[i][j] == 8, "R10 per-tile delivery count", PW'(got[i][j]), PW'(8));
  endtask

  initial begin
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 2; j++) rpi[i][j] = '0;
    t_reset();
    t_west_east();
    t_west_turn();
    t_north();
    t_deliver();
    t_inject();
    t_split_x();
    t_split_y();
    t_ring();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule